// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address for each beat of a four-beat burst in a pipelined synchronous SRAM controller. A load strobe captures a full starting address and the ordering choice, and each advance strobe then moves to the next beat. Only the two least significant address bits change during the burst; the bits above them stay at the value captured at load.

Two orderings are supported. In linear ordering each beat adds one, modulo four, to the captured low bits. In interleaved ordering each beat is the captured low bits XOR a beat index that counts from zero. After the fourth beat, the next advance returns the address to its starting value. A flag marks the fourth beat of the burst.

Top module: `burst_seq_top`

## Requirements
- R1: After a synchronous active-high reset, `burst_addr` is all zeros and `last_beat` is 0.
- R2: On the clock edge where `load` is high, the block captures `start_addr`. From the next cycle on, `burst_addr` equals the captured value and `last_beat` is 0.
- R3: If `order_sel` was 0 (linear) at load, then after n advances, `burst_addr[1:0]` equals (start[1:0] + n) mod 4.
- R4: If `order_sel` was 1 (interleaved) at load, then after n advances, `burst_addr[1:0]` equals start[1:0] XOR (n mod 4).
- R5: The advance that follows the fourth beat returns `burst_addr` to the captured start address.
- R6: When `load` and `advance` are high in the same cycle, the load takes effect and the advance is ignored. The beat index restarts at 0.
- R7: `last_beat` is 1 exactly when three, seven, eleven, … advances have occurred since the last load, which is the fourth beat.
- R8: `order_sel` is sampled only on a load edge. Changing it during a burst leaves the ordering of that burst unchanged.
- R9: `burst_addr[ADDR_W-1:2]` keeps the value captured at load, whatever advances occur.
- R10: In a cycle where neither `load` nor `advance` is high, `burst_addr` and `last_beat` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Starts a burst by capturing `start_addr` and `order_sel` |
| advance | input | 1 | Steps the burst by one beat |
| order_sel | input | 1 | Ordering choice: 0 linear, 1 interleaved; sampled at load |
| start_addr | input | ADDR_W | Burst starting address |
| burst_addr | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The hardest case to reach from the ports is a burst whose ordering input flips in the middle of the burst. A second hard case is a load that coincides with an advance right at the fourth beat. In both, a design that reads the live pin, or that lets the advance win, would drift away from the correct sequence only on certain start offsets. Directed bursts cover every start offset in both orderings, and each runs past the wrap. A directed sequence then toggles `order_sel` after a load in each mode and collides a load with an advance on the last beat. A seeded random phase mixes loads, advances and ordering changes, so that these events land on every beat position.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] base;
        logic [BEAT_W-1:0] idx;
        order_e            mode;
    } beat_state_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              order_sel_i,
    input  logic [BEAT_W-1:0] start_low_i,
    output beat_state_t       state_o
);
    beat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // load wins over a same-cycle advance
            st_d.base = start_low_i;
            st_d.idx  = '0;
            st_d.mode = order_e'(order_sel_i);
        end else if (adv_i) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  beat_state_t       state_i,
    output logic [BEAT_W-1:0] low_o,
    output logic              last_o
);
    always_comb begin
        unique case (state_i.mode)
            ORD_LINEAR:     low_o = state_i.base + state_i.idx;
            ORD_INTERLEAVE: low_o = state_i.base ^ state_i.idx;
            default:        low_o = state_i.base;
        endcase
        last_o = &state_i.idx;
    end
endmodule

// File: rtl/burst_upper_hold.sv
module burst_upper_hold #(
    parameter int UP_W = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [UP_W-1:0] upper_i,
    output logic [UP_W-1:0] upper_o
);
    logic [UP_W-1:0] up_d, up_q;

    always_comb begin
        up_d = up_q;
        if (load_i) up_d = upper_i;
    end

    always_ff @(posedge clk) begin
        if (rst) up_q <= '0;
        else     up_q <= up_d;
    end

    assign upper_o = up_q;
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              last_beat
);
    localparam int UP_W = ADDR_W - BEAT_W;

    beat_state_t       beat_state;
    logic [BEAT_W-1:0] low_addr;
    logic [UP_W-1:0]   up_addr;

    burst_beat_ctr u_ctr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .adv_i       (advance),
        .order_sel_i (order_sel),
        .start_low_i (start_addr[BEAT_W-1:0]),
        .state_o     (beat_state)
    );

    burst_order_map u_map (
        .state_i (beat_state),
        .low_o   (low_addr),
        .last_o  (last_beat)
    );

    burst_upper_hold #(.UP_W(UP_W)) u_up (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .upper_i (start_addr[ADDR_W-1:BEAT_W]),
        .upper_o (up_addr)
    );

    assign burst_addr = {up_addr, low_addr};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              last_beat
);
    logic [1:0] c_start, c_cnt;
    logic       c_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_start <= '0; c_cnt <= '0; c_mode <= 1'b0;
        end else if (load) begin
            c_start <= start_addr[1:0]; c_cnt <= '0; c_mode <= order_sel;
        end else if (advance) begin
            c_cnt <= c_cnt + 2'd1;
        end
    end

    p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (burst_addr == $past(start_addr)) && !last_beat);
    p_linear_r3: assert property (@(posedge clk) disable iff (rst)
        !c_mode |-> burst_addr[1:0] == 2'(c_start + c_cnt));
    p_interleave_r4: assert property (@(posedge clk) disable iff (rst)
        c_mode |-> burst_addr[1:0] == (c_start ^ c_cnt));
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && last_beat) |=> burst_addr[1:0] == $past(c_start));
    p_last_r7: assert property (@(posedge clk) disable iff (rst)
        last_beat == (c_cnt == 2'd3));
    p_upper_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(burst_addr[ADDR_W-1:2]));
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(burst_addr) && $stable(last_beat));
endmodule

bind burst_seq_top burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst, load, advance, order_sel;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] burst_addr;
    logic          last_beat;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] m_start;
    logic [1:0]    m_idx;
    logic          m_mode;

    burst_seq_top #(.ADDR_W(AW)) uut (.*);

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, logic [1:0] n, logic md);
        logic [1:0] lo;
        lo = md ? (s[1:0] ^ n) : 2'(s[1:0] + n);
        return {s[AW-1:2], lo};
    endfunction

    task automatic check(string tag);
        logic [AW-1:0] ea;
        logic          el;
        ea = exp_addr(m_start, m_idx, m_mode);
        el = (m_idx == 2'd3);
        checks++;
        if (burst_addr !== ea || last_beat !== el) begin
            fails++;
            $display("FAIL %s addr=%h last=%b expected addr=%h last=%b",
                     tag, burst_addr, last_beat, ea, el);
        end
    endtask

    task automatic cyc(logic ld, logic adv, logic sel, logic [AW-1:0] a, string tag);
        @(negedge clk);
        load = ld; advance = adv; order_sel = sel; start_addr = a;
        @(posedge clk);
        if (ld) begin m_start = a; m_idx = 2'd0; m_mode = sel; end
        else if (adv) m_idx = m_idx + 2'd1;
        #1;
        check(tag);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; load = 0; advance = 0; order_sel = 0; start_addr = '0;
        m_start = '0; m_idx = '0; m_mode = 0;
        repeat (3) @(posedge clk);
        #1; check("R1 reset");
        @(negedge clk); rst = 1'b0;

        // every start offset in both orderings, run past the wrap
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1, 0, md[0], {28'hA5C3_E10, 2'(s), 2'(s)}, "R2 load");
                for (int k = 0; k < 3; k++)
                    cyc(0, 1, md[0], '0, md ? "R4 interleaved" : "R3 linear");
                check("R7 last beat");
                cyc(0, 0, ~md[0], 32'hFFFF_FFFF, "R10 idle");
                cyc(0, 1, md[0], '0, "R5 wrap");
                check("R9 upper held");
            end
        end

        // ordering pin flips during bursts
        cyc(1, 0, 1'b0, 32'h1234_5671, "R2 load");
        cyc(0, 1, 1'b1, '0, "R8 sel ignored mid-burst");
        cyc(0, 1, 1'b1, '0, "R8 sel ignored mid-burst");
        cyc(1, 0, 1'b1, 32'h0BAD_F00E, "R2 load");
        cyc(0, 1, 1'b0, '0, "R8 sel ignored mid-burst");
        cyc(0, 1, 1'b0, '0, "R8 sel ignored mid-burst");
        cyc(0, 1, 1'b0, '0, "R7 last beat");

        // load colliding with advance, including on the last beat
        cyc(1, 1, 1'b0, 32'hCAFE_0003, "R6 load beats advance");
        cyc(0, 1, 1'b0, '0, "R3 linear");
        cyc(0, 1, 1'b0, '0, "R3 linear");
        cyc(0, 1, 1'b0, '0, "R7 last beat");
        cyc(1, 1, 1'b1, 32'h0000_0012, "R6 load beats advance");
        cyc(0, 1, 1'b1, '0, "R4 interleaved");

        // seeded random mix
        for (int i = 0; i < 600; i++) begin
            logic ld, adv, sel;
            ld  = ($urandom % 5) == 0;
            adv = ($urandom % 2) == 0;
            sel = 1'($urandom);
            cyc(ld, adv, sel, $urandom, ld ? "R2 R6 random load" :
                (m_mode ? "R4 R8 random" : "R3 R8 random"));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule